// File: doc/BRIEF.md
# Flash Write-Engine Status Register

This block holds the eight status bits of a flash write engine. Some of the bits are live. They report ready or busy and whether an erase or a program operation is suspended. The engine sets and clears these bits as it runs.

The other bits record errors, and they are sticky. These are the erase failure, program failure, low programming voltage and locked-sector flags. The engine can only set them. Only the clear-status command or a device reset removes them. Software can therefore run a series of operations and check the error bits once at the end.

The engine reports to the register through single-cycle event pulses. Host reads go through two active-low strobes, a chip select and an output enable. When the later of the two falls, the register takes a snapshot of the status byte. It drives that snapshot on the low byte of a 16-bit read word, with the upper byte at zero. The read word stays fixed until a strobe is raised and lowered again. This keeps the host from seeing a byte that changes partway through a status poll.

Top module: `fsr_status_reg`

## Requirements
- R1: After reset the status byte is 80h (ready, no flags set) and `rd_data` reads 0080h.
- R2: Bit map of the status byte: bit 7 ready, bit 6 erase suspended, bit 5 erase error, bit 4 program error, bit 3 programming-voltage low, bit 2 program suspended, bit 1 locked-sector attempt. Bit 0 and `rd_data[15:8]` always read zero.
- R3: Bits 5, 4, 3 and 1 are sticky. Once set, they stay set across any engine events until `clr_cmd` or reset.
- R4: `clr_cmd` clears bits 5, 4, 3 and 1 only. It leaves bits 7, 6 and 2 unchanged.
- R5: `ev_start` clears bit 7 (busy). `ev_done` sets bit 7 (ready).
- R6: `ev_susp_erase` sets bits 7 and 6. `ev_susp_prog` sets bits 7 and 2. `ev_resume` clears bits 6 and 2 and also clears bit 7, because the engine is busy again.
- R7: `ev_seq_err` sets bits 5 and 4 together. `ev_erase_err` sets bit 5. `ev_prog_err` sets bit 4. `ev_lock_err` sets bit 1.
- R8: Bit 3 is set only in a cycle where `vpp_chk` is high and `vpp_ok` is low. A low `vpp_ok` without `vpp_chk` has no effect.
- R9: When a bit is set and cleared in the same cycle, the set wins.
- R10: The snapshot is taken on the clock edge where `ce_n` and `oe_n` are first seen both low. It captures the status as of that edge, so it includes events registered one cycle earlier. `rd_data` then holds until one strobe is raised and both are low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low device reset |
| ev_start | input | 1 | Operation begins (engine busy) |
| ev_done | input | 1 | Operation finished (engine ready) |
| ev_susp_erase | input | 1 | Erase suspended |
| ev_susp_prog | input | 1 | Program suspended |
| ev_resume | input | 1 | Suspended operation resumed |
| ev_erase_err | input | 1 | Erase verify failed |
| ev_prog_err | input | 1 | Program verify failed |
| ev_seq_err | input | 1 | Bad command sequence |
| ev_lock_err | input | 1 | Write attempted to a locked sector |
| vpp_chk | input | 1 | Programming-voltage check point |
| vpp_ok | input | 1 | Programming voltage in range |
| clr_cmd | input | 1 | Clear-status command |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| rd_data | output | 16 | Status snapshot on the low byte, zero upper byte |

## Verification
The cases that matter most are those where a set event and a clear event hit the same bit in the same cycle. Three such pairs are exercised:
- `clr_cmd` together with `ev_erase_err`: the error bit must survive, while the other sticky bits are cleared.
- `ev_start` together with `ev_done`: the result must be ready.
- `ev_suspend` together with `ev_resume`: the register must end up suspended and ready.

Each pair is driven on one clock. A read cycle follows, and the captured byte is compared with the value that the set-wins rule predicts. A second class of overlap is an event that arrives while a read is already open. That case is judged by the snapshot holding until the strobes are toggled.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int STAT_W = 8;

    localparam int BIT_READY = 7;
    localparam int BIT_ESUSP = 6;
    localparam int BIT_EERR  = 5;
    localparam int BIT_PERR  = 4;
    localparam int BIT_VPP   = 3;
    localparam int BIT_PSUSP = 2;
    localparam int BIT_LOCK  = 1;

    // bits the engine itself may drop
    localparam logic [STAT_W-1:0] ENG_CLR_MASK = 8'b1100_0100;
    // bits only the clear command / reset may drop
    localparam logic [STAT_W-1:0] CMD_CLR_MASK = 8'b0011_1010;
    // bits that always read zero
    localparam logic [STAT_W-1:0] RSVD_MASK    = 8'b0000_0001;
    localparam logic [STAT_W-1:0] RESET_VAL    = 8'h80;

    typedef struct packed {
        logic start;
        logic done;
        logic susp_erase;
        logic susp_prog;
        logic resume;
        logic erase_err;
        logic prog_err;
        logic seq_err;
        logic lock_err;
        logic vpp_chk;
        logic vpp_ok;
        logic clr;
    } fsr_evt_t;

    typedef struct packed {
        logic              rd_q;
        logic [STAT_W-1:0] snap;
    } fsr_snap_st_t;

endpackage

// File: rtl/fsr_evt_map.sv
module fsr_evt_map
    import fsr_pkg::*;
(
    input  fsr_evt_t          evt,
    output logic [STAT_W-1:0] set_v,
    output logic [STAT_W-1:0] eng_clr_v,
    output logic [STAT_W-1:0] cmd_clr_v
);

    always_comb begin
        set_v     = '0;
        eng_clr_v = '0;
        cmd_clr_v = '0;

        set_v[BIT_READY] = evt.done | evt.susp_erase | evt.susp_prog;
        set_v[BIT_ESUSP] = evt.susp_erase;
        set_v[BIT_PSUSP] = evt.susp_prog;
        set_v[BIT_EERR]  = evt.erase_err | evt.seq_err;
        set_v[BIT_PERR]  = evt.prog_err  | evt.seq_err;
        set_v[BIT_VPP]   = evt.vpp_chk & ~evt.vpp_ok;
        set_v[BIT_LOCK]  = evt.lock_err;

        eng_clr_v[BIT_READY] = evt.start | evt.resume;
        eng_clr_v[BIT_ESUSP] = evt.resume;
        eng_clr_v[BIT_PSUSP] = evt.resume;

        cmd_clr_v = {STAT_W{evt.clr}};
    end

endmodule

// File: rtl/fsr_bit_cell.sv
module fsr_bit_cell #(
    parameter logic RST_VAL    = 1'b0,
    parameter bit   ENG_CLR_OK = 1'b0,
    parameter bit   CMD_CLR_OK = 1'b0,
    parameter bit   RESERVED   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic eng_clr_i,
    input  logic cmd_clr_i,
    output logic val_o
);

    logic val_d, val_q;
    logic clr_hit;

    always_comb begin
        clr_hit = (eng_clr_i & ENG_CLR_OK) | (cmd_clr_i & CMD_CLR_OK);
        if (RESERVED)      val_d = 1'b0;
        else if (set_i)    val_d = 1'b1;   // set has priority
        else if (clr_hit)  val_d = 1'b0;
        else               val_d = val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= RESERVED ? 1'b0 : RST_VAL;
        else        val_q <= val_d;
    end

    assign val_o = val_q;

endmodule

// File: rtl/fsr_read_snap.sv
module fsr_read_snap
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [STAT_W-1:0] stat_i,
    output logic [STAT_W-1:0] snap_o
);

    fsr_snap_st_t st_d, st_q;
    logic         rd_act;

    always_comb begin
        rd_act    = ~ce_n & ~oe_n;
        st_d      = st_q;
        st_d.rd_q = rd_act;
        // capture only when the later strobe completes the access
        if (rd_act && !st_q.rd_q) st_d.snap = stat_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rd_q <= 1'b0;
            st_q.snap <= RESET_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign snap_o = st_q.snap;

endmodule

// File: rtl/fsr_status_reg.sv
module fsr_status_reg
    import fsr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_start,
    input  logic              ev_done,
    input  logic              ev_susp_erase,
    input  logic              ev_susp_prog,
    input  logic              ev_resume,
    input  logic              ev_erase_err,
    input  logic              ev_prog_err,
    input  logic              ev_seq_err,
    input  logic              ev_lock_err,
    input  logic              vpp_chk,
    input  logic              vpp_ok,
    input  logic              clr_cmd,
    input  logic              ce_n,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PAD_W = DATA_W - STAT_W;

    fsr_evt_t          evt;
    logic [STAT_W-1:0] set_v, eng_clr_v, cmd_clr_v;
    logic [STAT_W-1:0] stat_q;
    logic [STAT_W-1:0] snap;

    always_comb begin
        evt.start      = ev_start;
        evt.done       = ev_done;
        evt.susp_erase = ev_susp_erase;
        evt.susp_prog  = ev_susp_prog;
        evt.resume     = ev_resume;
        evt.erase_err  = ev_erase_err;
        evt.prog_err   = ev_prog_err;
        evt.seq_err    = ev_seq_err;
        evt.lock_err   = ev_lock_err;
        evt.vpp_chk    = vpp_chk;
        evt.vpp_ok     = vpp_ok;
        evt.clr        = clr_cmd;
    end

    fsr_evt_map u_map (
        .evt       (evt),
        .set_v     (set_v),
        .eng_clr_v (eng_clr_v),
        .cmd_clr_v (cmd_clr_v)
    );

    for (genvar g = 0; g < STAT_W; g++) begin : g_bit
        fsr_bit_cell #(
            .RST_VAL    (RESET_VAL[g]),
            .ENG_CLR_OK (ENG_CLR_MASK[g]),
            .CMD_CLR_OK (CMD_CLR_MASK[g]),
            .RESERVED   (RSVD_MASK[g])
        ) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_i     (set_v[g]),
            .eng_clr_i (eng_clr_v[g]),
            .cmd_clr_i (cmd_clr_v[g]),
            .val_o     (stat_q[g])
        );
    end

    fsr_read_snap u_snap (
        .clk    (clk),
        .rst_n  (rst_n),
        .ce_n   (ce_n),
        .oe_n   (oe_n),
        .stat_i (stat_q),
        .snap_o (snap)
    );

    assign rd_data = {{PAD_W{1'b0}}, snap};

endmodule

// File: rtl/fsr_status_chk.sv
module fsr_status_chk
    import fsr_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ev_start,
    input logic              ev_done,
    input logic              ev_susp_erase,
    input logic              ev_susp_prog,
    input logic              ev_resume,
    input logic              ev_seq_err,
    input logic              vpp_chk,
    input logic              clr_cmd,
    input logic              ce_n,
    input logic              oe_n,
    input logic [DATA_W-1:0] rd_data,
    input logic [STAT_W-1:0] stat_q
);

    logic rd_act;
    assign rd_act = ~ce_n & ~oe_n;

    AST_UPPER_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:STAT_W] == '0 && rd_data[0] == 1'b0); // R2

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_cmd |=> ((stat_q | ~$past(stat_q)) & CMD_CLR_MASK) == CMD_CLR_MASK); // R3

    AST_CLR_KEEPS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_cmd && !ev_start && !ev_done && !ev_susp_erase && !ev_susp_prog && !ev_resume)
        |=> (stat_q & ENG_CLR_MASK) == ($past(stat_q) & ENG_CLR_MASK)); // R4

    AST_SUSP_SETS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ev_susp_erase |=> stat_q[BIT_READY] && stat_q[BIT_ESUSP]); // R6

    AST_SEQ_ERR_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        ev_seq_err |=> stat_q[BIT_EERR] && stat_q[BIT_PERR]); // R7

    AST_VPP_ONLY_ON_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_chk && !stat_q[BIT_VPP]) |=> !stat_q[BIT_VPP]); // R8

    AST_SNAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && $past(rd_act)) |=> $stable(rd_data)); // R10

endmodule

bind fsr_status_reg fsr_status_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_start      (ev_start),
    .ev_done       (ev_done),
    .ev_susp_erase (ev_susp_erase),
    .ev_susp_prog  (ev_susp_prog),
    .ev_resume     (ev_resume),
    .ev_seq_err    (ev_seq_err),
    .vpp_chk       (vpp_chk),
    .clr_cmd       (clr_cmd),
    .ce_n          (ce_n),
    .oe_n          (oe_n),
    .rd_data       (rd_data),
    .stat_q        (stat_q)
);

// File: tb/tb_fsr_status_reg.sv
module tb_fsr_status_reg;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_start = 0, ev_done = 0, ev_susp_erase = 0, ev_susp_prog = 0, ev_resume = 0;
    logic ev_erase_err = 0, ev_prog_err = 0, ev_seq_err = 0, ev_lock_err = 0;
    logic vpp_chk = 0, vpp_ok = 1, clr_cmd = 0;
    logic ce_n = 1, oe_n = 1;
    logic [15:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;   // 50 MHz

    fsr_status_reg dut (
        .clk(clk), .rst_n(rst_n),
        .ev_start(ev_start), .ev_done(ev_done),
        .ev_susp_erase(ev_susp_erase), .ev_susp_prog(ev_susp_prog),
        .ev_resume(ev_resume), .ev_erase_err(ev_erase_err),
        .ev_prog_err(ev_prog_err), .ev_seq_err(ev_seq_err),
        .ev_lock_err(ev_lock_err), .vpp_chk(vpp_chk), .vpp_ok(vpp_ok),
        .clr_cmd(clr_cmd), .ce_n(ce_n), .oe_n(oe_n), .rd_data(rd_data)
    );

    // event word: [11]clr [10]vpp_ok [9]start [8]done [7]susp_e [6]susp_p
    // [5]resume [4]erase_err [3]prog_err [2]seq_err [1]lock_err [0]vpp_chk
    // entry = {event word, expected status byte}
    localparam int NV = 21;
    localparam logic [19:0] VEC [NV] = '{
        {12'h600, 8'h00},  // R5 start -> busy
        {12'h508, 8'h90},  // R5 R7 done + program error
        {12'h600, 8'h10},  // R3 start keeps sticky bit 4
        {12'h101, 8'h98},  // R8 check with low voltage, done
        {12'hC00, 8'h80},  // R4 clear drops 4 and 3
        {12'h600, 8'h00},  // R5
        {12'h480, 8'hC0},  // R6 erase suspend
        {12'h420, 8'h00},  // R6 resume
        {12'h440, 8'h84},  // R6 program suspend
        {12'h520, 8'h80},  // R9 resume + done: ready wins
        {12'h402, 8'h82},  // R7 locked sector
        {12'h404, 8'hB2},  // R7 sequence error sets 5 and 4
        {12'hC10, 8'hA0},  // R9 clear + erase error: bit 5 survives
        {12'h401, 8'hA0},  // R8 check with good voltage
        {12'h000, 8'hA0},  // R8 low voltage without check ignored
        {12'hC00, 8'h80},  // R4
        {12'h700, 8'h80},  // R9 start + done
        {12'h600, 8'h00},  // R5
        {12'h4A0, 8'hC0},  // R9 suspend + resume: suspend wins
        {12'h420, 8'h00},  // R6
        {12'h500, 8'h80}   // R5
    };

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %04h expected %04h", tag, got, exp);
        end
    endtask

    task automatic drive_events(input logic [11:0] w);
        {clr_cmd, vpp_ok, ev_start, ev_done, ev_susp_erase, ev_susp_prog,
         ev_resume, ev_erase_err, ev_prog_err, ev_seq_err, ev_lock_err, vpp_chk} = w;
    endtask

    task automatic read_and_check(input logic [15:0] exp, input string tag);
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk); check(rd_data, exp, tag);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data, 16'h0080, "R1 reset value");
        read_and_check(16'h0080, "R1 reset read");

        for (int i = 0; i < NV; i++) begin
            @(negedge clk); drive_events(VEC[i][19:8]);
            @(negedge clk); drive_events(12'h400);
            ce_n = 1'b0; oe_n = 1'b0;
            @(negedge clk);
            check(rd_data, {8'h00, VEC[i][7:0]}, $sformatf("R2 table vector %0d", i));
            ce_n = 1'b1; oe_n = 1'b1;
        end

        // R10: later strobe governs capture
        @(negedge clk); ce_n = 1'b0;
        @(negedge clk); ev_lock_err = 1'b1;
        @(negedge clk); ev_lock_err = 1'b0; oe_n = 1'b0;
        @(negedge clk); check(rd_data, 16'h0082, "R10 capture on later fall");
        ev_prog_err = 1'b1;
        @(negedge clk); ev_prog_err = 1'b0;
        @(negedge clk); check(rd_data, 16'h0082, "R10 hold while open");
        oe_n = 1'b1;
        @(negedge clk); oe_n = 1'b0;
        @(negedge clk); check(rd_data, 16'h0092, "R10 update after toggle");
        ce_n = 1'b1; oe_n = 1'b1;

        // R3: reset clears sticky bits
        @(negedge clk); ev_seq_err = 1'b1;
        @(negedge clk); ev_seq_err = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        read_and_check(16'h0080, "R3 reset clears sticky");

        // R4: clear leaves erase-suspend alone
        @(negedge clk); ev_susp_erase = 1'b1; ev_lock_err = 1'b1;
        @(negedge clk); ev_susp_erase = 1'b0; ev_lock_err = 1'b0; clr_cmd = 1'b1;
        @(negedge clk); clr_cmd = 1'b0;
        read_and_check(16'h00C0, "R4 clear keeps suspend");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule